// File: doc/BRIEF.md
# Four-Slot Successive-Approximation Conversion Sequencer

This block paces an external 8-bit successive-approximation converter. A single start command launches a group of four conversions. Each conversion fills one slot of 32 clock-enable ticks. A slot opens with a sampling window. The trial code then resolves one bit at a time from the most significant bit down, and the slot's result register captures the code in the end phase. The analog parts sit outside: the block drives a trial code and a sample/hold strobe, and reads back a single comparator bit.

A group can run once and stop, or it can repeat for as long as the repeat input stays high, overwriting the four result registers each time. A completion flag rises when the fourth result of a group lands and stays set until the next start. The channel output either walks through four neighbouring channels or stays on one channel. A select input picks which of two tick sources paces the sequence: the system tick or a slower internal tick, meant for system clocks below about 750 kHz.

Top module: `sar_seq4_top`

## Requirements
- R1: After a start, the four conversions of the group are written in slot order to `res1`, `res2`, `res3` and `res4`. With an ideal comparator, each result equals the input level of the channel selected during that slot.
- R2: `done_flag` is low until the 125th active tick after the start edge. That tick writes `res4`, and `done_flag` is high from that same edge on.
- R3: With `cont_mode` low, `busy` stays high for exactly 128 active ticks after the start edge and then drops. While the block is idle, the result registers do not change.
- R4: With `cont_mode` high when a group ends, the next group begins on the following tick. `busy` stays high, `done_flag` stays set, and all four result registers are overwritten with new conversions.
- R5: Each slot lasts 32 active ticks. `sample_hold` is high during the first 12 ticks of every slot and low for the rest of the slot, which gives 48 sampling ticks per group.
- R6: Bits are resolved from bit 7 down to bit 0, two ticks per bit. The first tick of a bit's trial sets that bit. The second tick keeps the bit if `comp_in` is 1 (input at or above the trial code) and clears it otherwise. The trial code is 0 while sampling, so the first trial code after sampling is 0x80.
- R7: When `use_alt` is 0, only `sys_tick` advances the sequence. When `use_alt` is 1, only `alt_tick` advances it. The unselected tick has no effect.
- R8: A start pulse in the middle of a group aborts the group. `done_flag` is low on the next clock edge, and the sequence restarts at the first slot, phase 0.
- R9: `chan_sel` is loaded when each slot begins and is held for the whole slot. When `multi_ch` is 1, it is `{chan_in[2], slot}` with the slot numbered 0 to 3. When `multi_ch` is 0, it equals `chan_in`.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_tick | input | 1 | System clock-enable tick |
| alt_tick | input | 1 | Internal alternate clock-enable tick |
| use_alt | input | 1 | 1 selects alt_tick as the pacing source |
| start | input | 1 | Start, or abort and restart, a group |
| cont_mode | input | 1 | 1 repeats groups continuously |
| multi_ch | input | 1 | 1 steps through four channels, 0 holds one channel |
| chan_in | input | 3 | Channel, or group of channels in bit 2 |
| comp_in | input | 1 | Comparator: 1 when the input is at or above the trial code |
| trial_code | output | 8 | Trial code sent to the capacitor DAC |
| sample_hold | output | 1 | High while the input is being sampled |
| chan_sel | output | 3 | Channel being converted |
| busy | output | 1 | A group is in progress |
| done_flag | output | 1 | Conversion-complete flag |
| res1 | output | 8 | Result of slot 1 |
| res2 | output | 8 | Result of slot 2 |
| res3 | output | 8 | Result of slot 3 |
| res4 | output | 8 | Result of slot 4 |

## Verification
The assertions check the properties that hold on every cycle. A start always clears the flag and rewinds the counters. The flag only rises on the edge that loads the fourth register. The results stay frozen while the block is idle. Sampling only happens while busy and with the trial code cleared. The channel never moves inside a slot, and nothing advances without the selected tick. The bench's scenarios are needed for the properties that only show across a whole run: the exact tick counts for the flag and for the end of `busy`, the decoded values at the code boundaries 0x00, 0x7F, 0x80 and 0xFF, the overwrite in continuous mode, recovery after an abort, and pacing from the alternate tick.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int ADC_BITS      = 8;
    localparam int SLOTS         = 4;
    localparam int SLOT_TICKS    = 32;
    localparam int SAMPLE_TICKS  = 12;
    localparam int TICKS_PER_BIT = 2;
    localparam int END_TICKS     = 2;
    localparam int CHAN_W        = 3;

    // What a slot does at a given phase
    typedef enum logic [2:0] {
        ST_SAMPLE,
        ST_SET,
        ST_DECIDE,
        ST_WRITE,
        ST_END,
        ST_PAD
    } step_e;

    typedef struct packed {
        step_e      kind;
        logic [7:0] bitn;
    } step_t;

    // Map a phase count inside a slot to its action
    function automatic step_t decode_phase(int ph, int sample_t, int nbits,
                                           int per_bit, int end_t);
        step_t r;
        int    k;
        r.kind = ST_PAD;
        r.bitn = '0;
        k      = ph - sample_t;
        if (ph < sample_t) begin
            r.kind = ST_SAMPLE;
        end else if (k < nbits * per_bit) begin
            r.kind = ((k % per_bit) == 0) ? ST_SET : ST_DECIDE;
            r.bitn = 8'(nbits - 1 - k / per_bit);
        end else if (k == nbits * per_bit) begin
            r.kind = ST_WRITE;
        end else if (k < nbits * per_bit + end_t) begin
            r.kind = ST_END;
        end
        return r;
    endfunction

    // Channel for a slot: step inside a group of four, or hold one channel
    function automatic logic [CHAN_W-1:0] pick_chan(logic [CHAN_W-1:0] sel,
                                                    logic [1:0] slot,
                                                    logic multi);
        return multi ? {sel[CHAN_W-1:2], slot} : sel;
    endfunction

endpackage

// File: rtl/sar_seq_clksel.sv
module sar_seq_clksel (
    input  logic use_alt,
    input  logic sys_tick,
    input  logic alt_tick,
    output logic tick
);
    always_comb begin
        tick = use_alt ? alt_tick : sys_tick;
    end
endmodule

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
    import sar_seq_pkg::*;
#(
    parameter int N_SLOTS   = SLOTS,
    parameter int SLOT_LEN  = SLOT_TICKS,
    parameter int SAMP_LEN  = SAMPLE_TICKS,
    parameter int NBITS     = ADC_BITS,
    parameter int PER_BIT   = TICKS_PER_BIT,
    parameter int END_LEN   = END_TICKS,
    localparam int PH_W     = $clog2(SLOT_LEN),
    localparam int SL_W     = $clog2(N_SLOTS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            start,
    input  logic            cont,
    output logic            running,
    output logic [SL_W-1:0] slot,
    output logic [SL_W-1:0] slot_nxt,
    output logic [PH_W-1:0] phase,
    output step_t           step,
    output logic            adv,
    output logic            slot_end,
    output logic            flag
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_LEN - 1);
    localparam logic [SL_W-1:0] SL_LAST = SL_W'(N_SLOTS - 1);

    always_comb begin
        step     = decode_phase(int'(phase), SAMP_LEN, NBITS, PER_BIT, END_LEN);
        adv      = running && tick && !start;
        slot_end = adv && (phase == PH_LAST);
        slot_nxt = (slot == SL_LAST) ? '0 : slot + SL_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            slot    <= '0;
            phase   <= '0;
            flag    <= 1'b0;
        end else if (start) begin
            running <= 1'b1;
            slot    <= '0;
            phase   <= '0;
            flag    <= 1'b0;
        end else if (adv) begin
            if (step.kind == ST_WRITE && slot == SL_LAST) begin
                flag <= 1'b1;
            end
            if (phase == PH_LAST) begin
                phase <= '0;
                slot  <= slot_nxt;
                if (slot == SL_LAST && !cont) begin
                    running <= 1'b0;
                end
            end else begin
                phase <= phase + PH_W'(1);
            end
        end
    end
endmodule

// File: rtl/sar_seq_approx.sv
module sar_seq_approx
    import sar_seq_pkg::*;
#(
    parameter int NBITS    = ADC_BITS,
    localparam int BI_W    = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             adv,
    input  step_t            step,
    input  logic             comp_in,
    output logic [NBITS-1:0] trial
);
    logic [BI_W-1:0] bsel;

    always_comb begin
        bsel = step.bitn[BI_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            trial <= '0;
        end else if (adv) begin
            unique case (step.kind)
                ST_SAMPLE: trial       <= '0;
                ST_SET:    trial[bsel] <= 1'b1;
                ST_DECIDE: if (!comp_in) trial[bsel] <= 1'b0;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/sar_seq_results.sv
module sar_seq_results
    import sar_seq_pkg::*;
#(
    parameter int N_SLOTS  = SLOTS,
    parameter int NBITS    = ADC_BITS,
    localparam int SL_W    = $clog2(N_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          adv,
    input  step_t                         step,
    input  logic [SL_W-1:0]               slot,
    input  logic [NBITS-1:0]              trial,
    output logic [N_SLOTS-1:0][NBITS-1:0] res
);
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                res[i] <= '0;
            end else if (adv && step.kind == ST_WRITE && slot == SL_W'(i)) begin
                res[i] <= trial;
            end
        end
    end
endmodule

// File: rtl/sar_seq_chan.sv
module sar_seq_chan
    import sar_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              slot_end,
    input  logic [1:0]        slot_nxt,
    input  logic              multi,
    input  logic [CHAN_W-1:0] chan_in,
    output logic [CHAN_W-1:0] chan
);
    always_ff @(posedge clk) begin
        if (rst) begin
            chan <= '0;
        end else if (start) begin
            chan <= pick_chan(chan_in, 2'd0, multi);
        end else if (slot_end) begin
            chan <= pick_chan(chan_in, slot_nxt, multi);
        end
    end
endmodule

// File: rtl/sar_seq4_top.sv
module sar_seq4_top
    import sar_seq_pkg::*;
#(
    parameter int NBITS    = ADC_BITS,
    parameter int SLOT_LEN = SLOT_TICKS,
    parameter int SAMP_LEN = SAMPLE_TICKS,
    localparam int PH_W    = $clog2(SLOT_LEN),
    localparam int SL_W    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_tick,
    input  logic              alt_tick,
    input  logic              use_alt,
    input  logic              start,
    input  logic              cont_mode,
    input  logic              multi_ch,
    input  logic [CHAN_W-1:0] chan_in,
    input  logic              comp_in,
    output logic [NBITS-1:0]  trial_code,
    output logic              sample_hold,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              busy,
    output logic              done_flag,
    output logic [NBITS-1:0]  res1,
    output logic [NBITS-1:0]  res2,
    output logic [NBITS-1:0]  res3,
    output logic [NBITS-1:0]  res4
);
    logic                        tick;
    logic                        running;
    logic [SL_W-1:0]             slot_q;
    logic [SL_W-1:0]             slot_nxt;
    logic [PH_W-1:0]             phase_q;
    step_t                       step;
    logic                        adv;
    logic                        slot_end;
    logic                        flag;
    logic [SLOTS-1:0][NBITS-1:0] res_bank;

    sar_seq_clksel u_clk (
        .use_alt (use_alt),
        .sys_tick(sys_tick),
        .alt_tick(alt_tick),
        .tick    (tick)
    );

    sar_seq_timer #(
        .N_SLOTS (SLOTS),
        .SLOT_LEN(SLOT_LEN),
        .SAMP_LEN(SAMP_LEN),
        .NBITS   (NBITS),
        .PER_BIT (TICKS_PER_BIT),
        .END_LEN (END_TICKS)
    ) u_tim (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .start   (start),
        .cont    (cont_mode),
        .running (running),
        .slot    (slot_q),
        .slot_nxt(slot_nxt),
        .phase   (phase_q),
        .step    (step),
        .adv     (adv),
        .slot_end(slot_end),
        .flag    (flag)
    );

    sar_seq_approx #(.NBITS(NBITS)) u_sar (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .adv    (adv),
        .step   (step),
        .comp_in(comp_in),
        .trial  (trial_code)
    );

    sar_seq_results #(.N_SLOTS(SLOTS), .NBITS(NBITS)) u_res (
        .clk  (clk),
        .rst  (rst),
        .adv  (adv),
        .step (step),
        .slot (slot_q),
        .trial(trial_code),
        .res  (res_bank)
    );

    sar_seq_chan u_chan (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .slot_end(slot_end),
        .slot_nxt(slot_nxt),
        .multi   (multi_ch),
        .chan_in (chan_in),
        .chan    (chan_sel)
    );

    always_comb begin
        busy        = running;
        done_flag   = flag;
        sample_hold = running && (step.kind == ST_SAMPLE);
        res1        = res_bank[0];
        res2        = res_bank[1];
        res3        = res_bank[2];
        res4        = res_bank[3];
    end
endmodule

// File: rtl/sar_seq4_chk.sv
module sar_seq4_chk #(
    parameter int NBITS        = 8,
    parameter int PH_W         = 5,
    parameter int SL_W         = 2,
    parameter int SLOT_LEN     = 32,
    parameter int SAMP_LEN     = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             use_alt,
    input logic             sys_tick,
    input logic             alt_tick,
    input logic             busy,
    input logic             done_flag,
    input logic             sample_hold,
    input logic [NBITS-1:0] trial_code,
    input logic [2:0]       chan_sel,
    input logic [NBITS-1:0] res1,
    input logic [NBITS-1:0] res2,
    input logic [NBITS-1:0] res3,
    input logic [NBITS-1:0] res4,
    input logic [SL_W-1:0]  slot,
    input logic [PH_W-1:0]  ph
);
    logic sel_tick;
    always_comb sel_tick = use_alt ? alt_tick : sys_tick;

    // R2: the flag rises together with the last slot's result load
    p_flag_on_fourth_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> (res4 == $past(trial_code) && slot == '1));

    // R3: idle block leaves results untouched
    p_results_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(res1) && $stable(res2)
                               && $stable(res3) && $stable(res4)));

    // R5: sampling only inside the opening window of a running slot
    p_sample_window_r5: assert property (@(posedge clk) disable iff (rst)
        sample_hold |-> (busy && ph < PH_W'(SAMP_LEN)));

    // R6: trial code is cleared while sampling
    p_trial_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (sample_hold && ph != '0) |-> (trial_code == '0));

    // R7: nothing advances without the selected tick
    p_hold_still_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && !sel_tick) |=> ($stable(trial_code) && $stable(ph)
                                           && $stable(slot)));

    // R8: start clears the flag and rewinds to slot 1, phase 0
    p_start_rewind_r8: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done_flag && busy && slot == '0 && ph == '0));

    // R9: channel holds for the whole slot
    p_chan_steady_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && !(sel_tick && ph == PH_W'(SLOT_LEN - 1)))
            |=> $stable(chan_sel));
endmodule

bind sar_seq4_top sar_seq4_chk #(
    .NBITS   (NBITS),
    .PH_W    (PH_W),
    .SL_W    (SL_W),
    .SLOT_LEN(SLOT_LEN),
    .SAMP_LEN(SAMP_LEN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .use_alt    (use_alt),
    .sys_tick   (sys_tick),
    .alt_tick   (alt_tick),
    .busy       (busy),
    .done_flag  (done_flag),
    .sample_hold(sample_hold),
    .trial_code (trial_code),
    .chan_sel   (chan_sel),
    .res1       (res1),
    .res2       (res2),
    .res3       (res3),
    .res4       (res4),
    .slot       (slot_q),
    .ph         (phase_q)
);

// File: tb/tb_sar_seq4_top.sv
module tb_sar_seq4_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sys_tick = 1'b0;
    logic       alt_tick = 1'b0;
    logic       use_alt = 1'b0;
    logic       start = 1'b0;
    logic       cont_mode = 1'b0;
    logic       multi_ch = 1'b1;
    logic [2:0] chan_in = 3'd0;
    logic       comp_in;
    logic [7:0] trial_code;
    logic       sample_hold;
    logic [2:0] chan_sel;
    logic       busy;
    logic       done_flag;
    logic [7:0] res1, res2, res3, res4;

    logic [7:0] vin [8];
    logic [7:0] res_w [4];
    logic [7:0] exp_q [$];
    int         nchk = 0;
    int         nfail = 0;
    int         cyc = 0;
    int         sh_cnt = 0;
    logic       eff_tick;
    event       cmp_ev;

    always #4 clk = ~clk;

    sar_seq4_top dut (
        .clk(clk), .rst(rst), .sys_tick(sys_tick), .alt_tick(alt_tick),
        .use_alt(use_alt), .start(start), .cont_mode(cont_mode),
        .multi_ch(multi_ch), .chan_in(chan_in), .comp_in(comp_in),
        .trial_code(trial_code), .sample_hold(sample_hold), .chan_sel(chan_sel),
        .busy(busy), .done_flag(done_flag),
        .res1(res1), .res2(res2), .res3(res3), .res4(res4)
    );

    // Ideal comparator and analog inputs
    assign comp_in  = (vin[chan_sel] >= trial_code);
    assign eff_tick = use_alt ? alt_tick : sys_tick;
    assign res_w[0] = res1;
    assign res_w[1] = res2;
    assign res_w[2] = res3;
    assign res_w[3] = res4;

    // Tick sources: system every 2nd cycle, alternate every 3rd
    always @(negedge clk) begin
        cyc++;
        sys_tick = (cyc % 2 == 0);
        alt_tick = (cyc % 3 == 1);
    end

    always @(posedge clk) begin
        if (!rst && sample_hold && eff_tick) sh_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_chan(input int s);
        return multi_ch ? {chan_in[2], 2'(s)} : chan_in;
    endfunction

    // Driver side of the scoreboard
    task automatic push_expected();
        for (int s = 0; s < 4; s++) exp_q.push_back(vin[exp_chan(s)]);
    endtask

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (eff_tick) k++;
        end
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Walk one group tick by tick, checking timing on the way
    task automatic run_group(input bit first, input bit contm);
        sh_cnt = 0;
        for (int s = 0; s < 4; s++) begin
            wait_ticks(6);
            chk("R5 sample_hold high in window", 32'(sample_hold), 32'd1);
            chk("R9 channel for slot", 32'(chan_sel), 32'(exp_chan(s)));
            wait_ticks(6);
            chk("R5 sample_hold low after 12 ticks", 32'(sample_hold), 32'd0);
            wait_ticks(1);
            chk("R6 first trial is msb", 32'(trial_code), 32'h80);
            if (s < 3) wait_ticks(19);
        end
        wait_ticks(15);
        chk("R2 flag before fourth write", 32'(done_flag), first ? 32'd0 : 32'd1);
        wait_ticks(1);
        chk("R2 flag at fourth write", 32'(done_flag), 32'd1);
        -> cmp_ev;
        wait_ticks(2);
        chk("R3 busy through padding", 32'(busy), 32'd1);
        wait_ticks(1);
        if (contm) chk("R4 busy stays in repeat mode", 32'(busy), 32'd1);
        else       chk("R3 busy drops after 128 ticks", 32'(busy), 32'd0);
        chk("R5 sampling ticks per group", 32'(sh_cnt), 32'd48);
    endtask

    // Monitor side of the scoreboard
    initial begin
        forever begin
            @(cmp_ev);
            #1;
            for (int s = 0; s < 4; s++) begin
                if (exp_q.size() == 0) begin
                    chk("R1 scoreboard underflow", 32'd1, 32'd0);
                end else begin
                    chk($sformatf("R1 result of slot %0d", s + 1),
                        32'(res_w[s]), 32'(exp_q.pop_front()));
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) vin[i] = 8'(i * 37 + 11);
        repeat (4) @(negedge clk);
        chk("R10 reset trial_code", 32'(trial_code), 32'd0);
        chk("R10 reset busy", 32'(busy), 32'd0);
        chk("R10 reset flag", 32'(done_flag), 32'd0);
        chk("R10 reset sample_hold", 32'(sample_hold), 32'd0);
        chk("R10 reset results", 32'({res1, res2, res3, res4}), 32'd0);
        chk("R10 reset chan_sel", 32'(chan_sel), 32'd0);
        rst = 1'b0;

        // Single group, channels 0..3
        vin[0] = 8'h5A; vin[1] = 8'hA5; vin[2] = 8'h3C; vin[3] = 8'hC3;
        multi_ch = 1'b1; chan_in = 3'b001;
        push_expected();
        pulse_start();
        run_group(1'b1, 1'b0);
        wait_ticks(40);
        chk("R3 stays idle", 32'(busy), 32'd0);
        chk("R3 results kept", 32'({res1, res2, res3, res4}), 32'h5AA53CC3);

        // Single channel, full scale
        vin[5] = 8'hFF; multi_ch = 1'b0; chan_in = 3'd5;
        push_expected();
        pulse_start();
        run_group(1'b1, 1'b0);

        // Upper channel group, code boundaries
        vin[4] = 8'h00; vin[5] = 8'hFF; vin[6] = 8'h80; vin[7] = 8'h7F;
        multi_ch = 1'b1; chan_in = 3'b100;
        push_expected();
        pulse_start();
        run_group(1'b1, 1'b0);

        // Continuous: two groups back to back
        vin[0] = 8'h01; vin[1] = 8'h02; vin[2] = 8'hFE; vin[3] = 8'h81;
        chan_in = 3'b000; cont_mode = 1'b1;
        push_expected();
        pulse_start();
        run_group(1'b1, 1'b1);
        vin[0] = 8'h10; vin[1] = 8'h20; vin[2] = 8'h40; vin[3] = 8'h7E;
        push_expected();
        run_group(1'b0, 1'b1);
        chk("R4 second group overwrote", 32'({res1, res2, res3, res4}), 32'h1020407E);

        // Abort while running with the flag set
        pulse_start();
        chk("R8 flag cleared by start", 32'(done_flag), 32'd0);
        chk("R8 busy after restart", 32'(busy), 32'd1);
        cont_mode = 1'b0;
        wait_ticks(40);
        vin[0] = 8'h33; vin[1] = 8'hCC; vin[2] = 8'h55; vin[3] = 8'hAA;
        pulse_start();
        chk("R8 flag low after mid-group abort", 32'(done_flag), 32'd0);
        push_expected();
        run_group(1'b1, 1'b0);

        // Alternate tick source; system ticks keep toggling and must be ignored
        use_alt = 1'b1;
        vin[0] = 8'h99; vin[1] = 8'h66; vin[2] = 8'h0F; vin[3] = 8'hF0;
        push_expected();
        pulse_start();
        run_group(1'b1, 1'b0);
        chk("R7 alt-paced results", 32'({res1, res2, res3, res4}), 32'h99660FF0);

        repeat (4) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule